// File: doc/BRIEF.md
# PFC Mode and Fault Sequencer

This block decides, every clock, whether the power-factor boost stage may switch and in which operating mode it runs. It takes a digitised output-voltage sense current and an estimated-power value, both as codes scaled against a reference. It also takes die-temperature trip and clear flags, an active-low standby pin and a strobe that marks each line cycle. From these it produces a gate-enable, a two-bit mode code and a three-bit code naming the highest-priority reason switching is held off.

Output-voltage supervision uses two hysteretic windows. The lower window moves the controller between start-up and normal operation. The upper window blocks the gate on overvoltage. A sustained overload during start-up trips a timed hiccup: the gate stays off for a long fixed interval, then the stage retries. At very light load the controller enters burst operation. It then blanks the gate for a whole number of line cycles, and that number grows as the load estimate falls further below the burst level. All timers count clock ticks, scaled from a ticks-per-millisecond parameter.

Top module: `pfc_mode_seq`

## Requirements
- R1: While reset is held, gate_en is 0, mode is 3 (off) and cause is 1 (standby).
- R2: Mode code 0 means start-up and 1 means normal. After reset the block is in start-up. It enters normal one clock after fb_code reaches 95% of reference (code 190 with the default reference of 200).
- R3: From normal, fb_code below 85% of reference (code 169 or less) returns the block to start-up within one clock. Codes from 170 to 189 keep whichever of the two modes was already held.
- R4: fb_code above 107% of reference (215 or more) forces gate_en low, mode 3 and cause 4 one clock later. The gate stays off until fb_code is at or below 103% of reference (206). A code of 214 does not trip.
- R5: If pwr_code stays above 125% of full load (code 251 or more with a full-load code of 200) while in start-up for OP_MS milliseconds of ticks, gate_en drops with cause 3 for HICCUP_MS milliseconds of ticks. Start-up switching then resumes.
- R6: If the overload condition clears before its interval expires, the overload timer restarts from zero.
- R7: In normal mode, pwr_code below 5% of full load (code 9 or less) selects mode 2 (burst). The gate stays on until a line strobe. From that strobe it is off for (10 - pwr_code) x BURST_GAIN further line strobes, is then on for one line cycle, and the pattern repeats. Burst is never selected from start-up.
- R8: stby_n low forces gate_en low and cause 1 one clock later. Releasing it restores the previous mode one clock later.
- R9: A temp_trip pulse forces gate_en low with cause 2. The condition is held until a temp_clear pulse. A temp_clear pulse with no prior trip has no effect on gate_en.
- R10: The cause code shows the highest active disable, in the order standby (1), over-temperature (2), hiccup (3), overvoltage (4). Cause 0 occurs only when mode is not 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Active-low standby request |
| temp_trip | input | 1 | Die temperature above shutdown level |
| temp_clear | input | 1 | Die temperature below resume level |
| line_strb | input | 1 | One-clock pulse per line cycle |
| fb_code | input | FW | Output-voltage sense current code |
| pwr_code | input | PW | Estimated output power code |
| gate_en | output | 1 | Gate timer may switch |
| mode | output | 2 | 0 start-up, 1 normal, 2 burst, 3 off |
| cause | output | 3 | 0 none, 1 standby, 2 over-temperature, 3 hiccup, 4 overvoltage |

## Verification
A stuck or wrongly set hysteresis latch appears one clock after a threshold crossing. Either the mode code stays where it was inside the band edges, or it flips too early inside the band. An overload counter that fails to clear, or that counts outside start-up, shows as a gate drop earlier than the 448-tick interval used by the bench. A wrong off-count shows as a hiccup window that is too short or too long. A wrong burst count appears as the gate turning on one strobe early or late. A broken priority encoder shows at once in the cause code whenever two disables overlap.

// File: rtl/pfc_seq_pkg.sv
package pfc_seq_pkg;

   typedef enum logic [1:0] {
      MD_START = 2'd0,
      MD_RUN   = 2'd1,
      MD_BURST = 2'd2,
      MD_OFF   = 2'd3
   } pfc_mode_e;

   typedef enum logic [2:0] {
      CZ_NONE   = 3'd0,
      CZ_STBY   = 3'd1,
      CZ_HOT    = 3'd2,
      CZ_HICCUP = 3'd3,
      CZ_OVOLT  = 3'd4
   } pfc_cause_e;

   // scale a base code by a whole percentage
   function automatic int pct_of(input int base, input int pct);
      return (base * pct) / 100;
   endfunction

endpackage

// File: rtl/pfc_hyst_latch.sv
// Level comparator with a set point and a separate release point.
module pfc_hyst_latch #(
   parameter int W         = 9,
   parameter int SET_LVL   = 214,
   parameter int CLR_LVL   = 206,
   parameter bit HIGH_SIDE = 1'b1,
   parameter bit RST_VAL   = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   output logic         flag
);

   logic set_c;
   logic clr_c;

   if (SET_LVL >= (2 ** W) || CLR_LVL >= (2 ** W)) begin : g_range_bad
      $error("pfc_hyst_latch: threshold does not fit in W bits");
   end

   if (HIGH_SIDE) begin : g_high
      if (CLR_LVL >= SET_LVL) begin : g_order_bad
         $error("pfc_hyst_latch: release must lie below set point");
      end
      assign set_c = level >  W'(SET_LVL);
      assign clr_c = level <= W'(CLR_LVL);
   end else begin : g_low
      if (CLR_LVL <= SET_LVL) begin : g_order_bad
         $error("pfc_hyst_latch: release must lie above set point");
      end
      assign set_c = level <  W'(SET_LVL);
      assign clr_c = level >= W'(CLR_LVL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= RST_VAL;
      end else if (set_c) begin
         flag <= 1'b1;
      end else if (clr_c) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/pfc_op_hiccup.sv
// Overload persistence timer followed by a forced-off retry interval.
module pfc_op_hiccup #(
   parameter int OP_TICKS  = 448,
   parameter int OFF_TICKS = 12000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic overload,
   output logic hic_act
);

   localparam int OW = $clog2(OP_TICKS + 1);
   localparam int HW = $clog2(OFF_TICKS + 1);

   if (OP_TICKS < 1 || OFF_TICKS < 1) begin : g_len_bad
      $error("pfc_op_hiccup: intervals must be at least one tick");
   end

   logic [OW-1:0] op_cnt;
   logic [HW-1:0] off_cnt;
   logic          counting;
   logic          expire;

   assign hic_act  = (off_cnt != '0);
   assign counting = overload && !hic_act;
   assign expire   = counting && (op_cnt == OW'(OP_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_cnt <= '0;
      end else if (!counting || expire) begin
         op_cnt <= '0;
      end else begin
         op_cnt <= op_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_cnt <= '0;
      end else if (hic_act) begin
         off_cnt <= off_cnt - 1'b1;
      end else if (expire) begin
         off_cnt <= HW'(OFF_TICKS);
      end
   end

endmodule

// File: rtl/pfc_burst_gate.sv
// Light-load detection and line-cycle-quantised gate blanking.
module pfc_burst_gate #(
   parameter int PW   = 9,
   parameter int TH   = 10,
   parameter int GAIN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] pwr_code,
   input  logic          active,
   input  logic          line_strb,
   output logic          light_load,
   output logic          hold_off
);

   localparam int DW = $clog2(TH + 1);
   localparam int BW = $clog2(TH * GAIN + 1);

   if (TH < 1 || GAIN < 1 || TH >= (2 ** PW)) begin : g_par_bad
      $error("pfc_burst_gate: threshold or gain out of range");
   end

   logic [DW-1:0] deficit_q;
   logic [BW-1:0] load_v;
   logic [BW-1:0] off_cnt;
   logic          below;

   assign below = pwr_code < PW'(TH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         light_load <= 1'b0;
         deficit_q  <= '0;
      end else begin
         light_load <= below;
         deficit_q  <= below ? DW'(TH - int'(pwr_code)) : '0;
      end
   end

   if (GAIN == 1) begin : g_unit
      assign load_v = BW'(deficit_q);
   end else begin : g_scaled
      assign load_v = BW'(int'(deficit_q) * GAIN);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_cnt <= '0;
      end else if (!active) begin
         off_cnt <= '0;
      end else if (line_strb) begin
         off_cnt <= (off_cnt == '0) ? load_v : off_cnt - 1'b1;
      end
   end

   assign hold_off = (off_cnt != '0);

endmodule

// File: rtl/pfc_mode_seq.sv
module pfc_mode_seq
   import pfc_seq_pkg::*;
#(
   parameter int FW           = 9,
   parameter int PW           = 9,
   parameter int REF_CODE     = 200,
   parameter int FULL_CODE    = 200,
   parameter int UV_SET_PCT   = 85,
   parameter int UV_HYS_PCT   = 10,
   parameter int OV_SET_PCT   = 107,
   parameter int OV_HYS_PCT   = 4,
   parameter int OP_PCT       = 125,
   parameter int BURST_PCT    = 5,
   parameter int BURST_GAIN   = 1,
   parameter int TICKS_PER_MS = 100000,
   parameter int OP_MS        = 112,
   parameter int HICCUP_MS    = 3000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stby_n,
   input  logic          temp_trip,
   input  logic          temp_clear,
   input  logic          line_strb,
   input  logic [FW-1:0] fb_code,
   input  logic [PW-1:0] pwr_code,
   output logic          gate_en,
   output logic [1:0]    mode,
   output logic [2:0]    cause
);

   localparam int UV_SET       = pct_of(REF_CODE, UV_SET_PCT);
   localparam int UV_CLR       = pct_of(REF_CODE, UV_SET_PCT + UV_HYS_PCT);
   localparam int OV_SET       = pct_of(REF_CODE, OV_SET_PCT);
   localparam int OV_CLR       = pct_of(REF_CODE, OV_SET_PCT - OV_HYS_PCT);
   localparam int OP_LVL       = pct_of(FULL_CODE, OP_PCT);
   localparam int BURST_LVL    = pct_of(FULL_CODE, BURST_PCT);
   localparam int OP_TICKS     = TICKS_PER_MS * OP_MS;
   localparam int HICCUP_TICKS = TICKS_PER_MS * HICCUP_MS;

   if (OP_LVL >= (2 ** PW)) begin : g_op_bad
      $error("pfc_mode_seq: overload level does not fit in PW bits");
   end
   if (UV_CLR >= OV_CLR) begin : g_win_bad
      $error("pfc_mode_seq: undervoltage window overlaps overvoltage window");
   end

   logic       stby_lvl_q;
   logic       ot_hot;
   logic       uv_low;
   logic       ov_hi;
   logic       hic_act;
   logic       op_raw;
   logic       overload;
   logic       light_load;
   logic       hold_off;
   pfc_cause_e cause_w;
   pfc_mode_e  mode_w;

   // standby pin and thermal latch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stby_lvl_q <= 1'b0;
         ot_hot     <= 1'b0;
      end else begin
         stby_lvl_q <= stby_n;
         if (temp_trip) begin
            ot_hot <= 1'b1;
         end else if (temp_clear) begin
            ot_hot <= 1'b0;
         end
      end
   end

   pfc_hyst_latch #(
      .W(FW), .SET_LVL(UV_SET), .CLR_LVL(UV_CLR),
      .HIGH_SIDE(1'b0), .RST_VAL(1'b1)
   ) uv_i (
      .clk(clk), .rst_n(rst_n), .level(fb_code), .flag(uv_low)
   );

   pfc_hyst_latch #(
      .W(FW), .SET_LVL(OV_SET), .CLR_LVL(OV_CLR),
      .HIGH_SIDE(1'b1), .RST_VAL(1'b0)
   ) ov_i (
      .clk(clk), .rst_n(rst_n), .level(fb_code), .flag(ov_hi)
   );

   assign op_raw   = pwr_code > PW'(OP_LVL);
   assign overload = op_raw && uv_low && stby_lvl_q && !ot_hot && !ov_hi;

   pfc_op_hiccup #(
      .OP_TICKS(OP_TICKS), .OFF_TICKS(HICCUP_TICKS)
   ) hic_i (
      .clk(clk), .rst_n(rst_n), .overload(overload), .hic_act(hic_act)
   );

   // disable reason, highest priority first
   always_comb begin
      if (!stby_lvl_q) begin
         cause_w = CZ_STBY;
      end else if (ot_hot) begin
         cause_w = CZ_HOT;
      end else if (hic_act) begin
         cause_w = CZ_HICCUP;
      end else if (ov_hi) begin
         cause_w = CZ_OVOLT;
      end else begin
         cause_w = CZ_NONE;
      end
   end

   always_comb begin
      if (cause_w != CZ_NONE) begin
         mode_w = MD_OFF;
      end else if (uv_low) begin
         mode_w = MD_START;
      end else if (light_load) begin
         mode_w = MD_BURST;
      end else begin
         mode_w = MD_RUN;
      end
   end

   pfc_burst_gate #(
      .PW(PW), .TH(BURST_LVL), .GAIN(BURST_GAIN)
   ) burst_i (
      .clk(clk), .rst_n(rst_n), .pwr_code(pwr_code),
      .active(mode_w == MD_BURST), .line_strb(line_strb),
      .light_load(light_load), .hold_off(hold_off)
   );

   assign gate_en = (mode_w != MD_OFF) && !((mode_w == MD_BURST) && hold_off);
   assign mode    = mode_w;
   assign cause   = cause_w;

endmodule

// File: rtl/pfc_mode_seq_chk.sv
module pfc_mode_seq_chk #(
   parameter int FW           = 9,
   parameter int UV_SET       = 170,
   parameter int OV_SET       = 214,
   parameter int HICCUP_TICKS = 12000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stby_n,
   input logic [FW-1:0] fb_code,
   input logic          gate_en,
   input logic [1:0]    mode,
   input logic [2:0]    cause
);

   logic        armed;
   logic [31:0] hic_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         hic_run <= '0;
      end else begin
         armed   <= 1'b1;
         hic_run <= (cause == 3'd3) ? hic_run + 1'b1 : '0;
      end
   end

   // R8
   stby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && !$past(stby_n) |-> !gate_en && cause == 3'd1);

   // R4
   ov_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && ($past(fb_code) > FW'(OV_SET)) |-> !gate_en);

   // R3
   uv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed && ($past(fb_code) < FW'(UV_SET)) |-> mode == 2'd0 || mode == 2'd3);

   // R10
   cause_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause != 3'd0 |-> mode == 2'd3 && !gate_en);

   // R10
   none_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause == 3'd0 |-> mode != 2'd3);

   // R5
   hiccup_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hic_run <= 32'(HICCUP_TICKS));

endmodule

bind pfc_mode_seq pfc_mode_seq_chk #(
   .FW(FW), .UV_SET(UV_SET), .OV_SET(OV_SET), .HICCUP_TICKS(HICCUP_TICKS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .fb_code(fb_code),
   .gate_en(gate_en), .mode(mode), .cause(cause)
);

// File: tb/pfc_mode_seq_tb.sv
module pfc_mode_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TPM        = 4;
   localparam int OP_T       = TPM * 112;
   localparam int HIC_T      = TPM * 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stby_n = 1'b1;
   logic       temp_trip = 1'b0;
   logic       temp_clear = 1'b0;
   logic       line_strb = 1'b0;
   logic [8:0] fb_code = '0;
   logic [8:0] pwr_code = 9'd100;
   logic       gate_en;
   logic [1:0] mode;
   logic [2:0] cause;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pfc_mode_seq #(.TICKS_PER_MS(TPM)) dut_i (
      .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .temp_trip(temp_trip),
      .temp_clear(temp_clear), .line_strb(line_strb), .fb_code(fb_code),
      .pwr_code(pwr_code), .gate_en(gate_en), .mode(mode), .cause(cause)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_out(input string tag, input int g, input int m, input int c);
      chk({tag, " gate_en"}, int'(gate_en), g);
      chk({tag, " mode"}, int'(mode), m);
      chk({tag, " cause"}, int'(cause), c);
   endtask

   task automatic strobe(input int gap);
      line_strb = 1'b1;
      tick(1);
      line_strb = 1'b0;
      tick(gap);
   endtask

   task automatic t_reset();
      tick(2);
      chk_out("R1 in reset", 0, 3, 1);
      rst_n = 1'b1;
      tick(1);
      chk_out("R2 start after reset", 1, 0, 0);
   endtask

   task automatic t_uv();
      fb_code = 9'd180; tick(2);
      chk_out("R3 band from start-up", 1, 0, 0);
      fb_code = 9'd190; tick(1);
      chk_out("R2 reach normal", 1, 1, 0);
      fb_code = 9'd175; tick(1);
      chk_out("R3 band from normal", 1, 1, 0);
      fb_code = 9'd169; tick(1);
      chk_out("R3 drop to start-up", 1, 0, 0);
      fb_code = 9'd200; tick(1);
      chk_out("R2 back to normal", 1, 1, 0);
   endtask

   task automatic t_ov();
      fb_code = 9'd214; tick(1);
      chk_out("R4 at set point", 1, 1, 0);
      fb_code = 9'd215; tick(1);
      chk_out("R4 trip", 0, 3, 4);
      fb_code = 9'd207; tick(1);
      chk_out("R4 inside band", 0, 3, 4);
      fb_code = 9'd206; tick(1);
      chk_out("R4 release", 1, 1, 0);
      fb_code = 9'd200; tick(1);
   endtask

   task automatic t_stby();
      stby_n = 1'b0; tick(1);
      chk_out("R8 standby", 0, 3, 1);
      stby_n = 1'b1; tick(1);
      chk_out("R8 release", 1, 1, 0);
   endtask

   task automatic t_temp();
      temp_clear = 1'b1; tick(1); temp_clear = 1'b0;
      chk_out("R9 clear alone", 1, 1, 0);
      temp_trip = 1'b1; tick(1); temp_trip = 1'b0;
      chk_out("R9 trip", 0, 3, 2);
      tick(3);
      chk_out("R9 held", 0, 3, 2);
      temp_clear = 1'b1; tick(1); temp_clear = 1'b0;
      chk_out("R9 cleared", 1, 1, 0);
   endtask

   task automatic t_prio();
      temp_trip = 1'b1; fb_code = 9'd220; stby_n = 1'b0; tick(1);
      temp_trip = 1'b0;
      chk_out("R10 standby wins", 0, 3, 1);
      stby_n = 1'b1; tick(1);
      chk_out("R10 thermal over ov", 0, 3, 2);
      temp_clear = 1'b1; tick(1); temp_clear = 1'b0;
      chk_out("R10 ov left", 0, 3, 4);
      fb_code = 9'd200; tick(1);
      chk_out("R10 all clear", 1, 1, 0);
   endtask

   task automatic t_burst();
      pwr_code = 9'd6; tick(1);
      chk_out("R7 enter burst", 1, 2, 0);
      tick(5);
      chk_out("R7 on before strobe", 1, 2, 0);
      strobe(3);
      chk_out("R7 blank start", 0, 2, 0);
      strobe(3); strobe(3); strobe(3);
      chk_out("R7 still blank", 0, 2, 0);
      strobe(3);
      chk_out("R7 on after four cycles", 1, 2, 0);
      pwr_code = 9'd9; tick(1);
      strobe(2);
      chk_out("R7 one-cycle blank", 0, 2, 0);
      strobe(2);
      chk_out("R7 one-cycle end", 1, 2, 0);
      pwr_code = 9'd10; tick(1);
      chk_out("R7 at burst level", 1, 1, 0);
      fb_code = 9'd160; pwr_code = 9'd6; tick(1);
      chk_out("R7 none in start-up", 1, 0, 0);
      pwr_code = 9'd100; tick(1);
   endtask

   task automatic t_op();
      pwr_code = 9'd250; tick(OP_T + 5);
      chk_out("R5 at level no trip", 1, 0, 0);
      pwr_code = 9'd251; tick(OP_T - 1);
      chk_out("R5 before expiry", 1, 0, 0);
      tick(1);
      chk_out("R5 hiccup", 0, 3, 3);
      tick(HIC_T - 1);
      chk_out("R5 hiccup end-1", 0, 3, 3);
      tick(1);
      chk_out("R5 retry", 1, 0, 0);
      pwr_code = 9'd100; tick(1);
      pwr_code = 9'd300; tick(300);
      pwr_code = 9'd100; tick(1);
      pwr_code = 9'd300; tick(OP_T - 1);
      chk_out("R6 timer restarted", 1, 0, 0);
      tick(1);
      chk_out("R6 trip after full interval", 0, 3, 3);
      pwr_code = 9'd100; fb_code = 9'd200; tick(HIC_T);
      chk_out("R6 recover to normal", 1, 1, 0);
   endtask

   initial begin
      tick(1);
      t_reset();
      t_uv();
      t_ov();
      t_stby();
      t_temp();
      t_prio();
      t_burst();
      t_op();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule